// File: doc/BRIEF.md
# Timer Interrupt Level Arbiter and Vector Generator

This block gathers interrupt requests from a bank of timer submodules and presents them to a system bus that arbitrates by level. Each source carries a pending flag, a 3-bit request level and a single arbitration bit. Every pending source with a non-zero level raises the request line for that level. Sources programmed to level zero are disabled.

When the bus runs an arbitration cycle, it presents a level and a 4-bit priority code together with a one-cycle start strobe. The priority code the block can claim has two parts. Its upper three bits come from a shared register. Its lowest bit comes from the arbitration bit of the source. The block therefore answers to only two of the possible codes. The candidates are the sources that are pending at the arbitrated level and whose arbitration bit completes the presented code. If there is at least one candidate, the block wins, and the lowest-numbered candidate is chosen. Source numbers are the fixed input positions 0 up to NUM_SRC-1.

A two-state controller captures the result in registers. In `ARB_IDLE`, a start strobe with a candidate present takes the transition *claim* to `ARB_GRANT`. A start strobe with no candidate leaves the controller in `ARB_IDLE` through *decline*. In `ARB_GRANT`, the win flag, the winner index and the 8-bit vector are held. The transition *hold* keeps the controller there until an acknowledge is sampled, and the transition *release* then returns it to `ARB_IDLE`. The vector is made of two base bits followed by the winner number, zero-extended to six bits.

Top module: `tirq_arbiter`

## Requirements
- R1: Bit k-1 of `req_lines` (k = 1..7) is high, in the same cycle, exactly when at least one source has its pending flag set and its level field equal to k. A source with level 0 drives no line.
- R2: After reset, `arb_win` is 0, `win_src` is 0 and `irq_vec` is 0.
- R3: A start strobe sampled in `ARB_IDLE` makes `arb_win` 1 on the next cycle exactly when some pending source i meets two conditions: its level equals `arb_level`, and {`shared_prio`, `src_arb[i]`} equals `arb_prio`, with `shared_prio` as bits 3:1. Otherwise `arb_win` stays 0.
- R4: The captured `win_src` is the lowest index among the qualifying sources.
- R5: While `arb_win` is 1, `irq_vec` equals {`vec_base`, 6-bit zero-extended `win_src`}, with `vec_base` as bits 7:6 as sampled with the start strobe.
- R6: In `ARB_GRANT`, without an acknowledge, `arb_win`, `win_src` and `irq_vec` hold their values. Further start strobes and changes to any source input have no effect on them.
- R7: An acknowledge sampled in `ARB_GRANT` clears `arb_win`, `win_src` and `irq_vec` to 0 on the next cycle. An acknowledge sampled in `ARB_IDLE` has no effect.
- R8: An arbitration cycle at `arb_level` 0 never wins, even when sources are pending at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pend | input | 11 | Pending flag per source; bit i is source i |
| src_lvl | input | 33 | Level field per source; bits 3i+2:3i belong to source i |
| src_arb | input | 1 | ×11 → 11 bits; arbitration bit per source |
| shared_prio | input | 3 | Shared upper three bits of the priority code |
| vec_base | input | 2 | High-order vector bits |
| arb_start | input | 1 | One-cycle strobe that marks an arbitration cycle |
| arb_level | input | 3 | Level under arbitration |
| arb_prio | input | 4 | Priority code under arbitration |
| arb_ack | input | 1 | Acknowledge that releases a held grant |
| req_lines | output | 7 | Request line per level; bit k-1 is level k |
| arb_win | output | 1 | The block won the latest arbitration |
| win_src | output | 4 | Index of the winning source |
| irq_vec | output | 8 | Vector returned for the win |

## Verification
The assertions take for granted two things about the inputs. The start strobe and the acknowledge are sampled only on clock edges, and all source inputs are stable around each edge. They make no assumption about how often these strobes come, because the controller ignores a start in `ARB_GRANT` and an acknowledge in `ARB_IDLE`. To keep within this, the stimulus changes inputs two nanoseconds after each rising edge. A directed phase drives start and acknowledge in both states. A random phase also collides them with input changes, and it biases the priority code towards the two claimable values so that wins, losses and level-zero cycles all occur.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_GRANT = 1'b1
    } arb_state_e;

endpackage

// File: rtl/tirq_req_lines.sv
module tirq_req_lines #(
    parameter int NUM_SRC   = 11,
    parameter int LVL_W     = 3,
    localparam int NUM_LINES = (1 << LVL_W) - 1
) (
    input  logic [NUM_SRC-1:0]       src_pend,
    input  logic [NUM_SRC*LVL_W-1:0] src_lvl,
    output logic [NUM_LINES-1:0]     req_lines
);

    // one hit matrix row per level line, OR-reduced across sources
    for (genvar k = 1; k <= NUM_LINES; k++) begin : g_line
        logic [NUM_SRC-1:0] hit;
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            assign hit[i] = src_pend[i] && (src_lvl[i*LVL_W +: LVL_W] == LVL_W'(k));
        end
        assign req_lines[k-1] = |hit;
    end

endmodule

// File: rtl/tirq_pick.sv
module tirq_pick #(
    parameter int NUM_SRC = 11,
    parameter int LVL_W   = 3,
    parameter int PRIO_W  = 4,
    localparam int SHR_W  = PRIO_W - 1,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_pend,
    input  logic [NUM_SRC*LVL_W-1:0] src_lvl,
    input  logic [NUM_SRC-1:0]       src_arb,
    input  logic [SHR_W-1:0]         shared_prio,
    input  logic [LVL_W-1:0]         arb_level,
    input  logic [PRIO_W-1:0]        arb_prio,
    output logic                     any_hit,
    output logic [IDX_W-1:0]         win_idx,
    output logic [NUM_SRC-1:0]       win_mask
);

    logic [NUM_SRC-1:0] elig;

    // a source qualifies when it is pending at the arbitrated non-zero level
    // and its own bit completes the presented priority code
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign elig[i] = src_pend[i]
                      && (arb_level != '0)
                      && (src_lvl[i*LVL_W +: LVL_W] == arb_level)
                      && ({shared_prio, src_arb[i]} == arb_prio);
    end

    assign any_hit = |elig;

    // fixed priority: lowest index wins
    always_comb begin
        logic found;
        found    = 1'b0;
        win_idx  = '0;
        win_mask = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && !found) begin
                found       = 1'b1;
                win_idx     = IDX_W'(i);
                win_mask[i] = 1'b1;
            end
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_mask)); // R4
    AST_WIN_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (((win_mask & elig) == win_mask) && (((win_mask - NUM_SRC'(1)) & elig) == '0))); // R4
    AST_LEVEL_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_level == '0) |-> !any_hit); // R8

endmodule

// File: rtl/tirq_grant_fsm.sv
module tirq_grant_fsm
    import tirq_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter int VEC_BASE_W = 2,
    parameter int SRC_NUM_W  = 6,
    localparam int VEC_W     = VEC_BASE_W + SRC_NUM_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arb_start,
    input  logic                  arb_ack,
    input  logic                  any_hit,
    input  logic [IDX_W-1:0]      win_idx,
    input  logic [VEC_BASE_W-1:0] vec_base,
    output logic                  win_o,
    output logic [IDX_W-1:0]      idx_o,
    output logic [VEC_W-1:0]      vec_o
);

    arb_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (arb_start && any_hit) state_d = ARB_GRANT; // claim
            ARB_GRANT: if (arb_ack)              state_d = ARB_IDLE;  // release
            default:                             state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs, loaded on claim and cleared on release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_o <= 1'b0;
            idx_o <= '0;
            vec_o <= '0;
        end else begin
            unique case (state_q)
                ARB_IDLE: begin
                    if (arb_start && any_hit) begin
                        win_o <= 1'b1;
                        idx_o <= win_idx;
                        vec_o <= {vec_base, SRC_NUM_W'(win_idx)};
                    end
                end
                ARB_GRANT: begin
                    if (arb_ack) begin
                        win_o <= 1'b0;
                        idx_o <= '0;
                        vec_o <= '0;
                    end
                end
                default: begin
                    win_o <= 1'b0;
                    idx_o <= '0;
                    vec_o <= '0;
                end
            endcase
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_GRANT && !arb_ack) |=> (win_o && $stable(idx_o) && $stable(vec_o))); // R6
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_GRANT && arb_ack) |=> (!win_o && vec_o == '0 && idx_o == '0)); // R7
    AST_NO_SPONTANEOUS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && !arb_start) |=> !win_o); // R3
    AST_DECLINE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && arb_start && !any_hit) |=> !win_o); // R3

endmodule

// File: rtl/tirq_arbiter.sv
module tirq_arbiter #(
    parameter int NUM_SRC    = 11,
    parameter int LVL_W      = 3,
    parameter int PRIO_W     = 4,
    parameter int VEC_BASE_W = 2,
    parameter int SRC_NUM_W  = 6,
    localparam int NUM_LINES = (1 << LVL_W) - 1,
    localparam int SHR_W     = PRIO_W - 1,
    localparam int IDX_W     = $clog2(NUM_SRC),
    localparam int VEC_W     = VEC_BASE_W + SRC_NUM_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_pend,
    input  logic [NUM_SRC*LVL_W-1:0] src_lvl,
    input  logic [NUM_SRC-1:0]       src_arb,
    input  logic [SHR_W-1:0]         shared_prio,
    input  logic [VEC_BASE_W-1:0]    vec_base,
    input  logic                     arb_start,
    input  logic [LVL_W-1:0]         arb_level,
    input  logic [PRIO_W-1:0]        arb_prio,
    input  logic                     arb_ack,
    output logic [NUM_LINES-1:0]     req_lines,
    output logic                     arb_win,
    output logic [IDX_W-1:0]         win_src,
    output logic [VEC_W-1:0]         irq_vec
);

    logic               any_hit;
    logic [IDX_W-1:0]   pick_idx;
    logic [NUM_SRC-1:0] pick_mask;

    tirq_req_lines #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W)
    ) u_lines (
        .src_pend  (src_pend),
        .src_lvl   (src_lvl),
        .req_lines (req_lines)
    );

    tirq_pick #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .PRIO_W  (PRIO_W)
    ) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_pend    (src_pend),
        .src_lvl     (src_lvl),
        .src_arb     (src_arb),
        .shared_prio (shared_prio),
        .arb_level   (arb_level),
        .arb_prio    (arb_prio),
        .any_hit     (any_hit),
        .win_idx     (pick_idx),
        .win_mask    (pick_mask)
    );

    tirq_grant_fsm #(
        .IDX_W      (IDX_W),
        .VEC_BASE_W (VEC_BASE_W),
        .SRC_NUM_W  (SRC_NUM_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arb_start (arb_start),
        .arb_ack   (arb_ack),
        .any_hit   (any_hit),
        .win_idx   (pick_idx),
        .vec_base  (vec_base),
        .win_o     (arb_win),
        .idx_o     (win_src),
        .vec_o     (irq_vec)
    );

    AST_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pend == '0) |-> (req_lines == '0)); // R1
    AST_VEC_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        arb_win |-> (irq_vec[SRC_NUM_W-1:0] == SRC_NUM_W'(win_src))); // R5
    AST_IDLE_OUTPUTS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_win |-> (win_src == '0 && irq_vec == '0)); // R7

endmodule

// File: tb/tirq_arbiter_tb.sv
module tirq_arbiter_tb;

    localparam int N = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0]   src_pend = '0;
    logic [N*3-1:0] src_lvl = '0;
    logic [N-1:0]   src_arb = '0;
    logic [2:0]  shared_prio = '0;
    logic [1:0]  vec_base = '0;
    logic        arb_start = 1'b0;
    logic [2:0]  arb_level = '0;
    logic [3:0]  arb_prio = '0;
    logic        arb_ack = 1'b0;
    logic [6:0]  req_lines;
    logic        arb_win;
    logic [3:0]  win_src;
    logic [7:0]  irq_vec;

    int n_tests = 0;
    int n_fail  = 0;
    bit running = 0;

    // reference model state
    int m_grant = 0;
    int m_idx   = 0;
    int m_vec   = 0;

    always #5 clk = ~clk;

    tirq_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_lvl(src_lvl),
        .src_arb(src_arb), .shared_prio(shared_prio), .vec_base(vec_base),
        .arb_start(arb_start), .arb_level(arb_level), .arb_prio(arb_prio),
        .arb_ack(arb_ack), .req_lines(req_lines), .arb_win(arb_win),
        .win_src(win_src), .irq_vec(irq_vec)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lvl_of(input int i);
        return int'(src_lvl[i*3 +: 3]);
    endfunction

    function automatic int model_lines();
        int r = 0;
        for (int k = 1; k <= 7; k++)
            for (int i = 0; i < N; i++)
                if (src_pend[i] && lvl_of(i) == k) r |= (1 << (k - 1));
        return r;
    endfunction

    // behavioural model updated on each rising edge from sampled inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_grant = 0; m_idx = 0; m_vec = 0;
        end else if (m_grant != 0) begin
            if (arb_ack) begin
                m_grant = 0; m_idx = 0; m_vec = 0;
            end
        end else if (arb_start) begin
            for (int i = 0; i < N; i++) begin
                if (m_grant == 0 && src_pend[i] && arb_level != 0 && lvl_of(i) == int'(arb_level)
                    && ((int'(shared_prio) * 2 + int'(src_arb[i])) == int'(arb_prio))) begin
                    m_grant = 1;
                    m_idx   = i;
                    m_vec   = int'(vec_base) * 64 + i;
                end
            end
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (running && rst_n) begin
            chk("R1 req_lines", int'(req_lines), model_lines());
            chk("R3 arb_win", int'(arb_win), m_grant);
            chk("R4 win_src", int'(win_src), m_idx);
            chk("R5 irq_vec", int'(irq_vec), m_vec);
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic set_lvl(input int i, input int v);
        src_lvl[i*3 +: 3] = 3'(v);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R3 actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) cyc();
        chk("R2 reset arb_win", int'(arb_win), 0);
        chk("R2 reset win_src", int'(win_src), 0);
        chk("R2 reset irq_vec", int'(irq_vec), 0);
        rst_n = 1'b1;
        running = 1;
        cyc();

        // R1 / R4 / R5: sources 1,3,5,9 at level 4, source 0 at level 2
        shared_prio = 3'd5;
        vec_base    = 2'b10;
        src_pend    = '0;
        src_pend[0] = 1; set_lvl(0, 2);
        src_pend[1] = 1; set_lvl(1, 4); src_arb[1] = 0;
        src_pend[3] = 1; set_lvl(3, 4); src_arb[3] = 1;
        src_pend[5] = 1; set_lvl(5, 4); src_arb[5] = 1;
        src_pend[9] = 1; set_lvl(9, 4); src_arb[9] = 1;
        #1;
        chk("R1 lines levels 2 and 4", int'(req_lines), 8'h0A);
        arb_level = 3'd4; arb_prio = 4'd11; arb_start = 1;
        cyc();
        arb_start = 0;
        chk("R4 lowest qualifying wins", int'(win_src), 3);
        chk("R5 vector base and number", int'(irq_vec), 8'h83);

        // R6: inputs change and a new start is ignored while granted
        src_pend = '0; arb_prio = 4'd10; arb_start = 1;
        cyc();
        arb_start = 0;
        cyc();
        chk("R6 win held", int'(arb_win), 1);
        chk("R6 index held", int'(win_src), 3);
        chk("R6 vector held", int'(irq_vec), 8'h83);

        // R7: acknowledge releases
        arb_ack = 1;
        cyc();
        arb_ack = 0;
        chk("R7 release win", int'(arb_win), 0);
        chk("R7 release vector", int'(irq_vec), 0);

        // R3: arbitration bit 0 selects source 1
        src_pend = 11'b01000101011;
        arb_prio = 4'd10; arb_start = 1;
        cyc();
        arb_start = 0;
        chk("R3 arb bit selects source", int'(win_src), 1);
        chk("R5 vector source 1", int'(irq_vec), 8'h81);
        arb_ack = 1; cyc(); arb_ack = 0;

        // R3: shared bits mismatch -> no win
        arb_prio = 4'd3; arb_start = 1;
        cyc();
        arb_start = 0;
        chk("R3 shared mismatch no win", int'(arb_win), 0);

        // R8: level 0 sources and arbitration at level 0
        src_pend[2] = 1; set_lvl(2, 0); src_arb[2] = 1;
        arb_level = 3'd0; arb_prio = 4'd11; arb_start = 1;
        cyc();
        arb_start = 0;
        chk("R8 level zero no win", int'(arb_win), 0);

        // R7: ack in idle has no effect
        arb_ack = 1; cyc(); arb_ack = 0; cyc();
        chk("R7 idle ack no effect", int'(arb_win), 0);
        chk("R7 idle ack vector", int'(irq_vec), 0);

        // random phase
        for (int t = 0; t < 4000; t++) begin
            if ($urandom_range(0, 3) == 0) src_pend = N'($urandom);
            if ($urandom_range(0, 7) == 0) src_lvl  = (N*3)'({$urandom, $urandom});
            if ($urandom_range(0, 7) == 0) src_arb  = N'($urandom);
            if ($urandom_range(0, 31) == 0) shared_prio = 3'($urandom);
            vec_base  = 2'($urandom);
            arb_level = 3'($urandom);
            if ($urandom_range(0, 3) == 0) arb_prio = 4'($urandom);
            else arb_prio = {shared_prio, 1'($urandom)};
            arb_start = ($urandom_range(0, 2) == 0);
            arb_ack   = ($urandom_range(0, 3) == 0);
            cyc();
        end
        arb_start = 0; arb_ack = 0;
        cyc();
        running = 0;
        summary();
        $finish;
    end

endmodule